// File: doc/BRIEF.md
# Flash Block Erase/Program Manager

This block makes an on-chip register array behave like flash storage. A single command port takes three operations: read one word, program one word, and erase a whole block. The flash rules are enforced in hardware. A program can only clear bits, so the stored word becomes the bitwise AND of its old contents and the new data. The only way to bring bits back to 1 is a block erase, which sets every word of that block to all ones.

An erase walks the block one word per cycle. It then holds the port busy for a further programmable settling interval, which stands in for slow erase timing. Each block keeps its own erase count. The erase that brings the count to the endurance limit still completes, and the block is then retired as bad. Bad blocks refuse program and erase commands, and reads from them return all ones.

A command is accepted on a clock edge where `cmd_valid_i` is high and `busy_o` is low. Its result appears on `status_o` and `rdata_o` in the cycle where `done_o` is high.

Top module: `flash_mgr`

## Requirements
- R1: After reset every word reads as all ones, `busy_o` is low and no bit of `bad_blk_o` is set.
- R2: A read accepted at edge k raises `done_o` for the cycle after edge k, with `rdata_o` equal to the stored word and status 00 (ok). Read and program never raise `busy_o`.
- R3: A program whose data needs no 0-to-1 change stores the bitwise AND of the old word and the data, and reports status 00.
- R4: A program whose data has a 1 where the stored word has a 0 reports status 01 (program error) and leaves the word unchanged.
- R5: An erase sets every word of the addressed block (address bits above the word offset) to all ones and leaves the other blocks unchanged.
- R6: An accepted erase holds `busy_o` high for exactly BLOCK_WORDS + ERASE_CYCLES cycles, then raises `done_o` with status 00. Commands presented while `busy_o` is high are ignored.
- R7: Each block counts its completed erases. The erase that brings the count to ENDURANCE completes normally, and the block's bit in `bad_blk_o` is set from the `done_o` cycle onward.
- R8: A program or erase addressed to a bad block completes in one cycle with status 10 (bad block) and changes nothing.
- R9: A read addressed to a bad block returns all ones with status 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command request |
| cmd_op_i | input | 2 | 00 read, 01 program, 10 erase, 11 ignored |
| cmd_addr_i | input | log2(NUM_BLOCKS)+log2(BLOCK_WORDS) | Word address; upper bits select the block |
| cmd_wdata_i | input | DATA_W | Program data |
| busy_o | output | 1 | Erase in progress |
| done_o | output | 1 | One-cycle completion strobe |
| status_o | output | 2 | 00 ok, 01 program error, 10 bad block |
| rdata_o | output | DATA_W | Read result |
| bad_blk_o | output | NUM_BLOCKS | Retired block map |

## Verification
The hardest state to reach from the ports is a block that has just worn out. It takes ENDURANCE full erases, each lasting BLOCK_WORDS + ERASE_CYCLES cycles. The bench therefore builds the block with a small block size, a short settling time and an endurance of three. It erases one block repeatedly and checks that `bad_blk_o` stays clear before the last erase and is set after it. It then issues program, erase and read commands to the retired block. A command injected in the middle of an erase covers the rule that input is ignored while busy. That command would clear a word in another block, so a later read of that word shows whether it was ignored.

// File: rtl/flash_pkg.sv
package flash_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_PROG  = 2'b01,
    OP_ERASE = 2'b10,
    OP_NONE  = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    ST_OK    = 2'b00,
    ST_PERR  = 2'b01,
    ST_BAD   = 2'b10
  } status_e;
endpackage

// File: rtl/flash_array.sv
module flash_array #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 2048,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  // factory state is fully erased
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];

  a_r5_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/flash_wear.sv
module flash_wear #(
  parameter int NUM_BLOCKS = 4,
  parameter int ENDURANCE  = 50000,
  localparam int BLK_W     = $clog2(NUM_BLOCKS),
  localparam int CNT_W     = $clog2(ENDURANCE + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  erase_done_i,
  input  logic [BLK_W-1:0]      erase_blk_i,
  output logic [NUM_BLOCKS-1:0] bad_o
);
  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
    logic [CNT_W-1:0] cnt_q;
    logic             bad_q;
    logic             hit;

    assign hit = erase_done_i && (erase_blk_i == BLK_W'(b));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q <= '0;
        bad_q <= 1'b0;
      end else if (hit && !bad_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_W'(ENDURANCE - 1)) bad_q <= 1'b1;
      end
    end

    assign bad_o[b] = bad_q;

    a_r7_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= CNT_W'(ENDURANCE));
    a_r7_bad_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bad_q |=> bad_q);
    a_r7_bad_at_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(bad_q) |-> cnt_q == CNT_W'(ENDURANCE));
  end
endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int NUM_BLOCKS   = 4,
  parameter int BLOCK_WORDS  = 512,
  parameter int ERASE_CYCLES = 1000,
  localparam int WORD_W      = $clog2(BLOCK_WORDS),
  localparam int BLK_W       = $clog2(NUM_BLOCKS),
  localparam int ADDR_W      = WORD_W + BLK_W,
  localparam int TMR_W       = $clog2(ERASE_CYCLES + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cmd_valid_i,
  input  logic [1:0]            cmd_op_i,
  input  logic [ADDR_W-1:0]     cmd_addr_i,
  input  logic [DATA_W-1:0]     cmd_wdata_i,
  input  logic [NUM_BLOCKS-1:0] bad_i,
  input  logic [DATA_W-1:0]     arr_rdata_i,
  output logic [ADDR_W-1:0]     arr_raddr_o,
  output logic                  arr_we_o,
  output logic [ADDR_W-1:0]     arr_waddr_o,
  output logic [DATA_W-1:0]     arr_wdata_o,
  output logic                  erase_done_o,
  output logic [BLK_W-1:0]      erase_blk_o,
  output logic                  busy_o,
  output logic                  done_o,
  output logic [1:0]            status_o,
  output logic [DATA_W-1:0]     rdata_o
);
  typedef enum logic [1:0] {S_IDLE, S_FILL, S_WAIT} state_e;

  state_e            state_q;
  logic [BLK_W-1:0]  er_blk_q;
  logic [WORD_W-1:0] fill_idx_q;
  logic [TMR_W-1:0]  tmr_q;
  logic              done_q;
  status_e           status_q;
  logic [DATA_W-1:0] rdata_q;

  op_e               op;
  logic              accept;
  logic [BLK_W-1:0]  cmd_blk;
  logic              cmd_bad;
  logic              no_rise;
  logic              prog_ok;
  logic              wait_last;

  assign op        = op_e'(cmd_op_i);
  assign accept    = cmd_valid_i && (state_q == S_IDLE) && (op != OP_NONE);
  assign cmd_blk   = cmd_addr_i[ADDR_W-1:WORD_W];
  assign cmd_bad   = bad_i[cmd_blk];
  assign no_rise   = (cmd_wdata_i & ~arr_rdata_i) == '0;
  assign prog_ok   = accept && (op == OP_PROG) && !cmd_bad && no_rise;
  assign wait_last = (state_q == S_WAIT) && (tmr_q == TMR_W'(ERASE_CYCLES - 1));

  assign arr_raddr_o  = cmd_addr_i;
  assign arr_we_o     = prog_ok || (state_q == S_FILL);
  assign arr_waddr_o  = (state_q == S_FILL) ? {er_blk_q, fill_idx_q} : cmd_addr_i;
  assign arr_wdata_o  = (state_q == S_FILL) ? '1 : (arr_rdata_i & cmd_wdata_i);
  assign erase_done_o = wait_last;
  assign erase_blk_o  = er_blk_q;
  assign busy_o       = (state_q != S_IDLE);
  assign done_o       = done_q;
  assign status_o     = status_q;
  assign rdata_o      = rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      er_blk_q   <= '0;
      fill_idx_q <= '0;
      tmr_q      <= '0;
      done_q     <= 1'b0;
      status_q   <= ST_OK;
      rdata_q    <= '1;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (accept) begin
          unique case (op)
            OP_READ: begin
              rdata_q  <= cmd_bad ? '1 : arr_rdata_i;
              status_q <= ST_OK;
              done_q   <= 1'b1;
            end
            OP_PROG: begin
              status_q <= cmd_bad ? ST_BAD : (no_rise ? ST_OK : ST_PERR);
              done_q   <= 1'b1;
            end
            OP_ERASE: begin
              if (cmd_bad) begin
                status_q <= ST_BAD;
                done_q   <= 1'b1;
              end else begin
                er_blk_q   <= cmd_blk;
                fill_idx_q <= '0;
                state_q    <= S_FILL;
              end
            end
            default: ;
          endcase
        end
        S_FILL: begin
          fill_idx_q <= fill_idx_q + 1'b1;
          if (fill_idx_q == WORD_W'(BLOCK_WORDS - 1)) begin
            tmr_q   <= '0;
            state_q <= S_WAIT;
          end
        end
        S_WAIT: begin
          tmr_q <= tmr_q + 1'b1;
          if (wait_last) begin
            status_q <= ST_OK;
            done_q   <= 1'b1;
            state_q  <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  a_r6_busy_end_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  a_r8_bad_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && op != OP_READ && cmd_bad) |-> !arr_we_o);
  a_r4_perr_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && op == OP_PROG && !no_rise) |-> !arr_we_o);
  a_r2_read_no_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && op == OP_READ) |=> (done_o && !busy_o));
endmodule

// File: rtl/flash_mgr.sv
module flash_mgr #(
  parameter int DATA_W       = 16,
  parameter int NUM_BLOCKS   = 4,
  parameter int BLOCK_WORDS  = 512,
  parameter int ERASE_CYCLES = 1000,
  parameter int ENDURANCE    = 50000,
  localparam int WORD_W      = $clog2(BLOCK_WORDS),
  localparam int BLK_W       = $clog2(NUM_BLOCKS),
  localparam int ADDR_W      = WORD_W + BLK_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cmd_valid_i,
  input  logic [1:0]            cmd_op_i,
  input  logic [ADDR_W-1:0]     cmd_addr_i,
  input  logic [DATA_W-1:0]     cmd_wdata_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic [1:0]            status_o,
  output logic [DATA_W-1:0]     rdata_o,
  output logic [NUM_BLOCKS-1:0] bad_blk_o
);
  logic [ADDR_W-1:0] raddr, waddr;
  logic [DATA_W-1:0] ardata, awdata;
  logic              we, er_done;
  logic [BLK_W-1:0]  er_blk;

  flash_seq #(
    .DATA_W(DATA_W), .NUM_BLOCKS(NUM_BLOCKS),
    .BLOCK_WORDS(BLOCK_WORDS), .ERASE_CYCLES(ERASE_CYCLES)
  ) i_seq (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_op_i, .cmd_addr_i, .cmd_wdata_i,
    .bad_i(bad_blk_o), .arr_rdata_i(ardata), .arr_raddr_o(raddr),
    .arr_we_o(we), .arr_waddr_o(waddr), .arr_wdata_o(awdata),
    .erase_done_o(er_done), .erase_blk_o(er_blk),
    .busy_o, .done_o, .status_o, .rdata_o
  );

  flash_array #(.DATA_W(DATA_W), .DEPTH(NUM_BLOCKS * BLOCK_WORDS)) i_array (
    .clk_i, .rst_ni, .we_i(we), .waddr_i(waddr), .wdata_i(awdata),
    .raddr_i(raddr), .rdata_o(ardata)
  );

  flash_wear #(.NUM_BLOCKS(NUM_BLOCKS), .ENDURANCE(ENDURANCE)) i_wear (
    .clk_i, .rst_ni, .erase_done_i(er_done), .erase_blk_i(er_blk),
    .bad_o(bad_blk_o)
  );
endmodule

// File: tb/test_flash_mgr.sv
module test_flash_mgr;
  localparam int DW = 8, NB = 4, BW = 16, EC = 5, END = 3;
  localparam int AW = $clog2(NB) + $clog2(BW);

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic busy, done;
  logic [1:0] status;
  logic [DW-1:0] rdata;
  logic [NB-1:0] bad_blk;

  always #10 clk = ~clk;  // 50 MHz

  flash_mgr #(.DATA_W(DW), .NUM_BLOCKS(NB), .BLOCK_WORDS(BW),
              .ERASE_CYCLES(EC), .ENDURANCE(END)) i_flash_mgr (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_addr_i(cmd_addr), .cmd_wdata_i(cmd_wdata), .busy_o(busy),
    .done_o(done), .status_o(status), .rdata_o(rdata), .bad_blk_o(bad_blk));

  typedef struct {
    logic [1:0]    st;
    logic [DW-1:0] rd;
    bit            chk_rd;
    string         tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0, errors = 0;

  // reference model
  logic [DW-1:0] ref_mem [NB*BW];
  int ref_cnt [NB];
  bit ref_bad [NB];

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(status == e.st, {e.tag, " status"}, status, e.st);
        if (e.chk_rd) check(rdata == e.rd, {e.tag, " rdata"}, rdata, e.rd);
      end
    end
  end

  // driver: computes expectation, pushes it, drives the command
  task automatic issue(logic [1:0] op, int addr, logic [DW-1:0] data, string tag,
                       bit inj = 0, int inj_addr = 0);
    exp_t e;
    int blk, bc, exp_bc, guard;
    blk = addr / BW;
    exp_bc = 0;
    e.rd = '1; e.chk_rd = 0; e.tag = tag; e.st = 2'b00;
    case (op)
      2'b00: begin e.chk_rd = 1; e.rd = ref_bad[blk] ? '1 : ref_mem[addr]; end
      2'b01: begin
        if (ref_bad[blk]) e.st = 2'b10;
        else if ((data & ~ref_mem[addr]) != 0) e.st = 2'b01;
        else ref_mem[addr] = ref_mem[addr] & data;
      end
      default: begin
        if (ref_bad[blk]) e.st = 2'b10;
        else begin
          for (int w = 0; w < BW; w++) ref_mem[blk*BW + w] = '1;
          ref_cnt[blk]++;
          if (ref_cnt[blk] == END) ref_bad[blk] = 1;
          exp_bc = BW + EC;
        end
      end
    endcase
    @(negedge clk);
    while (busy) @(negedge clk);
    exp_q.push_back(e);
    cmd_op = op; cmd_addr = AW'(addr); cmd_wdata = data; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    bc = 0; guard = 0;
    while (!done && guard < 1000) begin
      if (busy) bc++;
      if (inj && bc == 2) begin
        cmd_op = 2'b01; cmd_addr = AW'(inj_addr); cmd_wdata = '0; cmd_valid = 1'b1;
      end else cmd_valid = 1'b0;
      guard++;
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    check(bc == exp_bc, {tag, " R6 busy cycles"}, bc, exp_bc);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog act=hung exp=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NB*BW; i++) ref_mem[i] = '1;
    for (int b = 0; b < NB; b++) begin ref_cnt[b] = 0; ref_bad[b] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(bad_blk == '0, "R1 bad map", bad_blk, 0);
    issue(2'b00, 0,  '0, "R1 read0");
    issue(2'b00, 21, '0, "R1 read21");
    issue(2'b00, 63, '0, "R1 read63");
    // R2 R3 programming clears bits
    issue(2'b01, 5, 8'hA5, "R3 prog A5");
    issue(2'b00, 5, '0,    "R2 read A5");
    issue(2'b01, 5, 8'h21, "R3 prog subset");
    issue(2'b00, 5, '0,    "R3 read 21");
    // R4 0->1 rejected
    issue(2'b01, 5, 8'h80, "R4 prog rise");
    issue(2'b00, 5, '0,    "R4 unchanged");
    issue(2'b01, 20, 8'h0F, "R3 prog blk1");
    issue(2'b00, 20, '0,    "R2 read blk1");
    // R5 R6 erase block 0 with a command injected while busy
    issue(2'b10, 3, '0, "R5 erase blk0", 1, 40);
    issue(2'b00, 5,  '0, "R5 blk0 erased");
    issue(2'b00, 15, '0, "R5 blk0 last word");
    issue(2'b00, 20, '0, "R5 blk1 kept");
    issue(2'b00, 40, '0, "R6 injected ignored");
    // R7 wear out block 2
    issue(2'b10, 32, '0, "R7 erase blk2 #1");
    issue(2'b01, 34, 8'h00, "R7 prog blk2");
    issue(2'b10, 33, '0, "R7 erase blk2 #2");
    check(bad_blk[2] == 1'b0, "R7 not yet bad", bad_blk[2], 0);
    issue(2'b01, 34, 8'h00, "R7 prog blk2 again");
    issue(2'b00, 34, '0,    "R7 read blk2");
    issue(2'b10, 47, '0, "R7 erase blk2 #3");
    check(bad_blk == 4'b0100, "R7 marked bad", bad_blk, 4'b0100);
    // R8 R9 bad block behaviour
    issue(2'b01, 33, 8'h00, "R8 prog bad");
    issue(2'b10, 33, '0,    "R8 erase bad");
    issue(2'b00, 33, '0,    "R9 read bad");
    check(bad_blk == 4'b0100, "R8 map stable", bad_blk, 4'b0100);
    // other blocks still usable
    issue(2'b01, 50, 8'h3C, "R3 prog blk3");
    issue(2'b00, 50, '0,    "R2 read blk3");
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R2 all done", exp_q.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule